// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function peripheral chip that sits on a byte-wide I/O bus. Software reaches it through an index/data register pair. A write to the index port picks a configuration register, and the next access to the data port reads or writes that register. A strap pin selects which of two port pairs the block decodes: 0x4E/0x4F or 0x2E/0x2F.

Configuration access is locked at reset. To open it, software writes the unlock key to the index port twice in a row. One write of a dedicated exit byte to the index port locks it again. While the port is open, a logical-device-number register picks which device's bank the per-device indices address. Each bank holds an enable, a 16-bit base address and an IRQ select. The block drives these on decoded outputs for every device at all times. Two read-only global identifiers, a chip ID and a vendor ID, are also visible.

Every bus access completes in the cycle it is presented. Reads are combinational and writes take effect at the next clock edge. The block has no stream interface, so there is no valid/ready handshake and no back-pressure: the bus is never stalled.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, and every device output reads disabled, with base address 0 and IRQ 0.
- R2: The port unlocks only after two index-port writes of 0x87 in a row. A single 0x87 does not unlock it, and any other index-port write between the two 0x87 writes restarts the sequence.
- R3: An index-port write of 0xAA while unlocked locks the port again, and that write does not change the selected index.
- R4: While locked, reads of the index or data port return 0xFF, and data-port writes change nothing.
- R5: With strap_alt low the port pair is 0x4E (index) and 0x4F (data); with strap_alt high it is 0x2E and 0x2F. A read at any other address returns 0xFF, and writes there have no effect.
- R6: While unlocked, an index-port write stores the register index, and a read of the index port returns that index.
- R7: Index 0x07 is the logical-device number. Per-device indices address the bank that this number selects. With a number at or above NUM_LDEV, per-device reads return 0xFF and per-device writes are dropped.
- R8: Indices 0x20/0x21 read the chip ID high and low bytes, and 0x23/0x24 read the vendor ID high and low bytes. Data writes to these indices are ignored.
- R9: Per-device index 0x30 holds the enable in bit 0, and its other bits read as 0. Index 0x60 holds base address bits 15:8 and index 0x61 holds bits 7:0. Index 0x70 holds an IRQ number of IRQ_W bits that reads back zero-extended, with upper written bits dropped.
- R10: A data-port write to a device register updates the decoded outputs from the next clock edge. Device registers and the logical-device number keep their values across lock and unlock.
- R11: Any index not listed above reads 0x00 while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Port pair select: 0 = 0x4E/0x4F, 1 = 0x2E/0x2F |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when nothing responds |
| dev_en | output | NUM_LDEV | Enable for each logical device |
| dev_base | output | NUM_LDEV*16 | Base address for each device, device i at bits [16i+15:16i] |
| dev_irq | output | NUM_LDEV*IRQ_W | IRQ select for each device, device i at bits [IRQ_W*i +: IRQ_W] |

## Verification
The bound checker watches on every cycle that the port only opens on the cycle after a key write, and that the exit byte closes it. It also watches that locked or foreign-address reads float to 0xFF, and that no decoded output moves while the port is locked. Other behaviour depends on register contents and so only the bench's reference model can show it. This covers aborted key sequences restarting, bank selection by the device number, out-of-range numbers, masking of the enable and IRQ fields, the read-only identifiers, the strap moving the port pair, and values surviving a relock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_ARMED = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  localparam logic [7:0] IX_LDN       = 8'h07;
  localparam logic [7:0] IX_CHIP_HI   = 8'h20;
  localparam logic [7:0] IX_CHIP_LO   = 8'h21;
  localparam logic [7:0] IX_VEND_HI   = 8'h23;
  localparam logic [7:0] IX_VEND_LO   = 8'h24;
  localparam logic [7:0] IX_DEV_EN    = 8'h30;
  localparam logic [7:0] IX_DEV_BASEH = 8'h60;
  localparam logic [7:0] IX_DEV_BASEL = 8'h61;
  localparam logic [7:0] IX_DEV_IRQ   = 8'h70;

  function automatic logic is_dev_index(input logic [7:0] ix);
    return (ix == IX_DEV_EN) || (ix == IX_DEV_BASEH) ||
           (ix == IX_DEV_BASEL) || (ix == IX_DEV_IRQ);
  endfunction

endpackage

// File: rtl/sio_unlock.sv
module sio_unlock
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);

  lock_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_SHUT;
    end else if (idx_wr) begin
      unique case (state_q)
        LK_SHUT:  state_q <= (wdata == KEY_BYTE) ? LK_ARMED : LK_SHUT;
        LK_ARMED: state_q <= (wdata == KEY_BYTE) ? LK_OPEN : LK_SHUT;
        LK_OPEN:  state_q <= (wdata == EXIT_BYTE) ? LK_SHUT : LK_OPEN;
        default:  state_q <= LK_SHUT;
      endcase
    end
  end

  assign cfg_open = (state_q == LK_OPEN);

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_stb,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic             en,
  output logic [15:0]      base,
  output logic [IRQ_W-1:0] irq,
  output logic [7:0]       rd_val
);

  localparam int PAD_W = 8 - IRQ_W;

  logic do_wr;
  assign do_wr = sel && wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      base <= '0;
      irq  <= '0;
    end else if (do_wr) begin
      unique case (idx)
        IX_DEV_EN:    en          <= wdata[0];
        IX_DEV_BASEH: base[15:8]  <= wdata;
        IX_DEV_BASEL: base[7:0]   <= wdata;
        IX_DEV_IRQ:   irq         <= wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      IX_DEV_EN:    rd_val = {7'd0, en};
      IX_DEV_BASEH: rd_val = base[15:8];
      IX_DEV_BASEL: rd_val = base[7:0];
      IX_DEV_IRQ:   rd_val = {{PAD_W{1'b0}}, irq};
      default:      rd_val = 8'h00;
    endcase
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDEV  = 4,
  parameter int          ADDR_W    = 16,
  parameter int          IRQ_W     = 4,
  parameter logic [15:0] CHIP_ID   = 16'h0B3C,
  parameter logic [15:0] VENDOR_ID = 16'h5A19,
  parameter logic [7:0]  KEY_BYTE  = 8'h87,
  parameter logic [7:0]  EXIT_BYTE = 8'hAA
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strap_alt,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic                      io_wr,
  input  logic                      io_rd,
  input  logic [7:0]                io_wdata,
  output logic [7:0]                io_rdata,
  output logic [NUM_LDEV-1:0]       dev_en,
  output logic [NUM_LDEV*16-1:0]    dev_base,
  output logic [NUM_LDEV*IRQ_W-1:0] dev_irq
);

  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam logic [7:0] LDEV_LIMIT = 8'(NUM_LDEV);
  localparam logic [ADDR_W-1:0] PRI_IDX = ADDR_W'(16'h004E);
  localparam logic [ADDR_W-1:0] ALT_IDX = ADDR_W'(16'h002E);

  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              idx_hit, dat_hit, idx_wr, dat_wr;
  logic              cfg_open;
  logic [7:0]        cur_idx, ldn;
  logic              ldn_ok;
  logic [LDN_W-1:0]  ldn_sel;
  logic [7:0]        bank_rd [NUM_LDEV];
  logic [7:0]        reg_val;

  assign idx_addr = strap_alt ? ALT_IDX : PRI_IDX;
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign idx_hit  = (io_addr == idx_addr);
  assign dat_hit  = (io_addr == dat_addr);
  assign idx_wr   = io_wr && idx_hit;
  assign dat_wr   = io_wr && dat_hit && cfg_open;

  sio_unlock #(
    .KEY_BYTE (KEY_BYTE),
    .EXIT_BYTE(EXIT_BYTE)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .wdata   (io_wdata),
    .cfg_open(cfg_open)
  );

  // index and device-number registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= 8'h00;
      ldn     <= 8'h00;
    end else begin
      if (idx_wr && cfg_open && (io_wdata != EXIT_BYTE)) cur_idx <= io_wdata;
      if (dat_wr && (cur_idx == IX_LDN)) ldn <= io_wdata;
    end
  end

  assign ldn_ok  = (ldn < LDEV_LIMIT);
  assign ldn_sel = ldn[LDN_W-1:0];

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
    logic             b_en;
    logic [15:0]      b_base;
    logic [IRQ_W-1:0] b_irq;

    sio_ldev_bank #(.IRQ_W(IRQ_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (ldn_ok && (ldn_sel == LDN_W'(g))),
      .wr_stb(dat_wr),
      .idx   (cur_idx),
      .wdata (io_wdata),
      .en    (b_en),
      .base  (b_base),
      .irq   (b_irq),
      .rd_val(bank_rd[g])
    );

    assign dev_en[g]                = b_en;
    assign dev_base[g*16 +: 16]     = b_base;
    assign dev_irq[g*IRQ_W +: IRQ_W] = b_irq;
  end

  // register read selection
  always_comb begin
    if (is_dev_index(cur_idx)) begin
      reg_val = ldn_ok ? bank_rd[ldn_sel] : 8'hFF;
    end else begin
      unique case (cur_idx)
        IX_LDN:     reg_val = ldn;
        IX_CHIP_HI: reg_val = CHIP_ID[15:8];
        IX_CHIP_LO: reg_val = CHIP_ID[7:0];
        IX_VEND_HI: reg_val = VENDOR_ID[15:8];
        IX_VEND_LO: reg_val = VENDOR_ID[7:0];
        default:    reg_val = 8'h00;
      endcase
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && cfg_open) begin
      if (idx_hit)      io_rdata = cur_idx;
      else if (dat_hit) io_rdata = reg_val;
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int         NUM_LDEV  = 4,
  parameter int         ADDR_W    = 16,
  parameter int         IRQ_W     = 4,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      strap_alt,
  input logic [ADDR_W-1:0]         io_addr,
  input logic                      io_wr,
  input logic                      io_rd,
  input logic [7:0]                io_wdata,
  input logic [7:0]                io_rdata,
  input logic [NUM_LDEV-1:0]       dev_en,
  input logic [NUM_LDEV*16-1:0]    dev_base,
  input logic [NUM_LDEV*IRQ_W-1:0] dev_irq,
  input logic                      cfg_open
);

  logic [ADDR_W-1:0] port_a;
  logic              at_idx, at_dat;
  assign port_a = strap_alt ? ADDR_W'(16'h002E) : ADDR_W'(16'h004E);
  assign at_idx = (io_addr == port_a);
  assign at_dat = (io_addr == port_a + ADDR_W'(1));

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == KEY_BYTE));

  // R3
  exit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && at_idx && io_wdata == EXIT_BYTE) |=> !cfg_open);

  // R4
  locked_read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> (io_rdata == 8'hFF));

  // R5
  foreign_read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !at_idx && !at_dat) |-> (io_rdata == 8'hFF));

  // R10
  locked_outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .NUM_LDEV (NUM_LDEV),
  .ADDR_W   (ADDR_W),
  .IRQ_W    (IRQ_W),
  .KEY_BYTE (KEY_BYTE),
  .EXIT_BYTE(EXIT_BYTE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strap_alt(strap_alt),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .dev_en   (dev_en),
  .dev_base (dev_base),
  .dev_irq  (dev_irq),
  .cfg_open (cfg_open)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = 4;
  localparam logic [15:0] CHIP = 16'h0B3C;
  localparam logic [15:0] VEND = 16'h5A19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [N-1:0] dev_en;
  logic [N*16-1:0] dev_base;
  logic [N*IW-1:0] dev_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .dev_en(dev_en), .dev_base(dev_base), .dev_irq(dev_irq)
  );

  // behavioural reference state
  int   m_lock = 0;  // 0 locked, 1 one key seen, 2 open
  int   m_idx = 0;
  int   m_ldn = 0;
  bit   m_en[N];
  int   m_base[N];
  int   m_irq[N];
  int   n_vec = 0, n_bad = 0;

  function automatic int port_of();
    return strap_alt ? 'h2E : 'h4E;
  endfunction

  function automatic logic [7:0] model_reg();
    if (m_idx == 'h30 || m_idx == 'h60 || m_idx == 'h61 || m_idx == 'h70) begin
      if (m_ldn >= N) return 8'hFF;
      if (m_idx == 'h30) return m_en[m_ldn] ? 8'h01 : 8'h00;
      if (m_idx == 'h60) return 8'((m_base[m_ldn] >> 8) & 'hFF);
      if (m_idx == 'h61) return 8'(m_base[m_ldn] & 'hFF);
      return 8'(m_irq[m_ldn]);
    end
    case (m_idx)
      'h07: return 8'(m_ldn);
      'h20: return CHIP[15:8];
      'h21: return CHIP[7:0];
      'h23: return VEND[15:8];
      'h24: return VEND[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input int a, input bit r);
    if (!r || m_lock != 2) return 8'hFF;
    if (a == port_of()) return 8'(m_idx);
    if (a == port_of() + 1) return model_reg();
    return 8'hFF;
  endfunction

  task automatic model_clock(input int a, input bit w, input int d);
    if (!w) return;
    if (a == port_of()) begin
      if (m_lock == 2) begin
        if (d == 'hAA) m_lock = 0;
        else m_idx = d;
      end else if (d == 'h87) m_lock = m_lock + 1;
      else m_lock = 0;
    end else if (a == port_of() + 1 && m_lock == 2) begin
      if (m_idx == 'h07) m_ldn = d;
      else if (m_ldn < N) begin
        case (m_idx)
          'h30: m_en[m_ldn] = d[0];
          'h60: m_base[m_ldn] = (m_base[m_ldn] & 'h00FF) | (d << 8);
          'h61: m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | d;
          'h70: m_irq[m_ldn] = d & ((1 << IW) - 1);
          default: ;
        endcase
      end
    end
  endtask

  // one bus cycle: drive, compare everything, advance the clock
  task automatic step(input int a, input bit w, input bit r, input int d, input string tag);
    logic [7:0] exp_rd;
    logic [N-1:0] exp_en;
    logic [N*16-1:0] exp_base;
    logic [N*IW-1:0] exp_irq;
    io_addr = 16'(a); io_wr = w; io_rd = r; io_wdata = 8'(d);
    #1;
    exp_rd = model_rd(a, r);
    for (int i = 0; i < N; i++) begin
      exp_en[i] = m_en[i];
      exp_base[i*16 +: 16] = 16'(m_base[i]);
      exp_irq[i*IW +: IW] = IW'(m_irq[i]);
    end
    n_vec++;
    if (io_rdata !== exp_rd || dev_en !== exp_en || dev_base !== exp_base || dev_irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: rdata %h/%h en %b/%b base %h/%h irq %h/%h (actual/expected)",
               tag, io_rdata, exp_rd, dev_en, exp_en, dev_base, exp_base, dev_irq, exp_irq);
    end
    @(posedge clk);
    model_clock(a, w, d);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic wi(input int d, input string tag); step(port_of(), 1, 0, d, tag); endtask
  task automatic wd(input int d, input string tag); step(port_of() + 1, 1, 0, d, tag); endtask
  task automatic ri(input string tag); step(port_of(), 0, 1, 0, tag); endtask
  task automatic rd(input string tag); step(port_of() + 1, 0, 1, 0, tag); endtask
  task automatic sel_rd(input int ix, input string tag); wi(ix, tag); rd(tag); endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_base[i] = 0; m_irq[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step('h4F, 0, 1, 0, "R1");
    ri("R1");
    // R4 locked accesses
    wd('h55, "R4");
    rd("R4");
    // R2 single key, aborted sequence
    wi('h87, "R2");
    rd("R2");
    wi('h07, "R2");
    wi('h87, "R2");
    rd("R2");
    wi('h87, "R2");
    // R6 index readback
    wi('h20, "R6");
    ri("R6");
    // R8 identifiers, read-only
    rd("R8");
    sel_rd('h21, "R8");
    sel_rd('h23, "R8");
    sel_rd('h24, "R8");
    wi('h20, "R8"); wd('h55, "R8"); rd("R8");
    // R11 unlisted index
    sel_rd('h45, "R11");
    // R5 foreign address ignored
    step('h1234, 1, 0, 'h00, "R5");
    step('h0050, 0, 1, 0, "R5");
    // R7 bank 2 programming
    wi('h07, "R7"); wd(2, "R7"); rd("R7");
    wi('h30, "R10"); wd('h01, "R10");
    wi('h60, "R10"); wd('hC2, "R10");
    wi('h61, "R10"); wd('h90, "R10");
    wi('h70, "R9"); wd('hFB, "R9"); rd("R9");
    sel_rd('h30, "R9");
    sel_rd('h60, "R9");
    // R7 bank 0 differs
    wi('h07, "R7"); wd(0, "R7");
    wi('h61, "R7"); wd('h3A, "R7"); rd("R7");
    wi('h30, "R9"); wd('hFE, "R9"); rd("R9");
    wd('h03, "R9"); rd("R9");
    // R7 out-of-range device number
    wi('h07, "R7"); wd(7, "R7");
    wi('h30, "R7"); wd('h01, "R7"); rd("R7");
    wi('h70, "R7"); wd('h05, "R7"); rd("R7");
    // R3 exit, index kept
    wi('h07, "R3"); wd(2, "R3");
    wi('hAA, "R3");
    rd("R3"); ri("R3");
    wd('h03, "R10");
    wi('h87, "R10"); wi('h87, "R10");
    ri("R3");
    rd("R10");
    sel_rd('h61, "R10");
    wi('hAA, "R3");
    // R5 strap moves the pair
    strap_alt = 1'b1;
    step('h4E, 1, 0, 'h87, "R5");
    step('h4E, 1, 0, 'h87, "R5");
    step('h4F, 0, 1, 0, "R5");
    rd("R5");
    wi('h87, "R5"); wi('h87, "R5");
    sel_rd('h07, "R5");
    step('h4F, 0, 1, 0, "R5");
    wi('h70, "R9"); wd('h1C, "R9"); rd("R9");
    wi('hAA, "R3");
    step('h0000, 0, 0, 0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule